// File: doc/BRIEF.md
# Sample-Queued Pulse-Width Modulator

This block drives one pulse-width modulated output from a small set of word-wide registers on a simple read/write bus. Software programs a period length and a clock divider, then pushes duty values into a four-entry queue. The period counter takes one queued duty value each time a new period begins. Software can therefore line up several duty changes ahead of time and let the hardware apply them on period edges, with no glitches.

Each period begins with the output high. The output goes low once the period counter reaches the duty value in use. The counter advances once per divided clock tick. One period lasts the programmed period value plus two ticks. A status word reports how many queue slots are in use and whether a write was lost. A self-clearing reset bit empties the queue and returns every register to zero.

Top module: `pwm_fifo_top`

## Requirements
- R1: After the reset input is released, the control, status, period and unmapped reads all return 0, and `pwm_out` is low.
- R2: Registers sit at byte offsets 0x00 (control), 0x04 (status, read-only), 0x0C (sample, write-only, reads 0) and 0x10 (period, low 16 bits). Other offsets read 0. Control keeps bit 0 (enable), bits [15:4] (divider), bits [17:16] (clock select), and bits 22, 23 and 24 (stored mode enables with no further effect). All other control bits read 0.
- R3: The queue holds 4 samples. Status bits [2:0] give the number of occupied slots, and they change on the clock edge that accepts a write or takes a sample.
- R4: A sample write that arrives while status bits [2:0] read 4 is discarded, even if a sample is taken in the same cycle. It also sets status bit 4, which stays set until a software reset.
- R5: Samples are used in the order written. One is taken when counting starts and one at each period boundary. If the queue is empty at a boundary, the previous sample is used again.
- R6: With period value P, one output period lasts P+2 counter ticks.
- R7: With divider field N, the counter advances once every N+1 clock cycles.
- R8: The output is high for the first min(S, P+2) ticks of each period, where S is the sample in use. A sample of 0 keeps the output low; a sample of P+2 or more keeps it high.
- R9: With control bit 0 clear, the counter stops and the output is low within one cycle.
- R10: A clock select value of 0 stops the counter, which keeps the output low. Values 1 to 3 run the counter from the block clock.
- R11: Writing control with bit 3 set clears control and period at once, and bit 3 reads 1 for exactly one cycle. On the next edge the queue and the overflow flag are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (5) | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with its default parameters: a four-deep queue, 16-bit period and sample, and a 12-bit divider. The vector table uses divider values from 0 to 99 and period values from 0 to 20, on every non-zero clock select. This covers the shortest two-tick period, a duty value one tick short of the full period, and periods of several hundred clocks. Because the queue is shallow, five back-to-back writes are enough to reach the overflow drop and the refill-and-drain order. The last queued duty value then repeats on an empty queue.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;
    // Byte offsets on the register bus
    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_STATUS = 'h04;
    localparam int OFF_SAMPLE = 'h0C;
    localparam int OFF_PERIOD = 'h10;

    // Control word bit positions
    localparam int CB_EN      = 0;
    localparam int CB_SWRST   = 3;
    localparam int CB_DIV_LO  = 4;
    localparam int DIV_W      = 12;
    localparam int CB_SEL_LO  = 16;
    localparam int SEL_W      = 2;

    // Bits that a control write keeps (enable, divider, select, three mode enables)
    localparam logic [31:0] CTRL_KEEP = 32'h01C3_FFF1;

    // Status word layout
    localparam int SB_OVF     = 4;

    function automatic logic [31:0] pack_status(input logic [7:0] occ, input logic ovf);
        logic [31:0] s;
        s = 32'(occ);
        s[SB_OVF] = ovf;
        return s;
    endfunction
endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
    import pwm_fifo_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         ctrl_word,
    output logic [PERIOD_W-1:0] period_val,
    output logic                swrst
);
    typedef struct packed {
        logic [31:0]         ctrl;
        logic [PERIOD_W-1:0] period;
        logic                swr;
    } regs_t;

    regs_t r_q, r_d;
    logic  hit_ctrl, hit_period;

    always_comb begin
        hit_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
        hit_period = bus_wr && (bus_addr == ADDR_W'(OFF_PERIOD));
        r_d        = r_q;
        r_d.swr    = 1'b0;
        if (hit_ctrl) begin
            if (bus_wdata[CB_SWRST]) begin
                r_d.ctrl   = '0;
                r_d.period = '0;
                r_d.swr    = 1'b1;
            end else begin
                r_d.ctrl = bus_wdata & CTRL_KEEP;
            end
        end
        if (hit_period && !(hit_ctrl && bus_wdata[CB_SWRST])) begin
            r_d.period = bus_wdata[PERIOD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        ctrl_word           = r_q.ctrl;
        ctrl_word[CB_SWRST] = r_q.swr;
    end
    assign period_val = r_q.period;
    assign swrst      = r_q.swr;

    // R11: reset bit is visible for one cycle only
    assert_swr_selfclear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.swr |=> !r_q.swr);
    // R11: while reset bit reads 1 the stored control fields are clear
    assert_swr_clears_ctrl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.swr) |-> (r_q.ctrl == '0 && r_q.period == '0));
endmodule

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int DEPTH    = 4,
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                push,
    input  logic [SAMPLE_W-1:0] push_data,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] head,
    output logic                empty,
    output logic [7:0]          occupancy,
    output logic                overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][SAMPLE_W-1:0] mem;
        logic [PTR_W-1:0]               wp;
        logic [PTR_W-1:0]               rp;
        logic [OCC_W-1:0]               cnt;
        logic                           ovf;
    } fifo_t;

    fifo_t f_q, f_d;
    logic  full, do_pop, do_push;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        full    = (f_q.cnt == OCC_W'(DEPTH));
        do_pop  = pop && (f_q.cnt != '0);
        do_push = push && !full;
        f_d     = f_q;
        if (flush) begin
            f_d.wp  = '0;
            f_d.rp  = '0;
            f_d.cnt = '0;
            f_d.ovf = 1'b0;
        end else begin
            if (do_pop) f_d.rp = nxt(f_q.rp);
            if (do_push) begin
                f_d.mem[f_q.wp] = push_data;
                f_d.wp          = nxt(f_q.wp);
            end
            if (push && full) f_d.ovf = 1'b1;
            f_d.cnt = f_q.cnt + OCC_W'(do_push) - OCC_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head      = f_q.mem[f_q.rp];
    assign empty     = (f_q.cnt == '0);
    assign occupancy = 8'(f_q.cnt);
    assign overflow  = f_q.ovf;

    // R3: occupancy never passes the depth
    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= OCC_W'(DEPTH));
    // R3: an accepted write with no pop grows occupancy by one on the next edge
    assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush && !pop && f_q.cnt < OCC_W'(DEPTH)) |=> (f_q.cnt == $past(f_q.cnt) + OCC_W'(1)));
    // R4: a write into a full queue leaves it full and raises the flag
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush && !pop && f_q.cnt == OCC_W'(DEPTH)) |=> (f_q.cnt == OCC_W'(DEPTH) && f_q.ovf));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] pre;
    } pre_t;

    pre_t p_q, p_d;

    always_comb begin
        tick = run && (p_q.pre >= div);
        if (!run || tick) p_d.pre = '0;
        else              p_d.pre = p_q.pre + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // R7: every tick restarts the divider count
    assert_tick_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (p_q.pre == '0));
endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
    parameter int PERIOD_W = 16,
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                run,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] period_val,
    input  logic [SAMPLE_W-1:0] fifo_head,
    input  logic                fifo_empty,
    output logic                fifo_pop,
    output logic                counting,
    output logic                pwm_out
);
    localparam int CNT_W = PERIOD_W + 1;
    localparam int CMP_W = (SAMPLE_W > CNT_W) ? SAMPLE_W : CNT_W;

    typedef struct packed {
        logic                loaded;
        logic [CNT_W-1:0]    cnt;
        logic [SAMPLE_W-1:0] cur;
    } core_t;

    core_t c_q, c_d;
    logic  at_end;

    always_comb begin
        at_end   = c_q.cnt >= (CNT_W'(period_val) + CNT_W'(1));
        c_d      = c_q;
        fifo_pop = 1'b0;
        if (clear) begin
            c_d = '0;
        end else if (!run) begin
            c_d.loaded = 1'b0;
            c_d.cnt    = '0;
        end else if (!c_q.loaded) begin
            c_d.loaded = 1'b1;
            c_d.cnt    = '0;
            if (!fifo_empty) begin
                fifo_pop = 1'b1;
                c_d.cur  = fifo_head;
            end
        end else if (tick) begin
            if (at_end) begin
                c_d.cnt = '0;
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    c_d.cur  = fifo_head;
                end
            end else begin
                c_d.cnt = c_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign counting = c_q.loaded;
    assign pwm_out  = c_q.loaded && (CMP_W'(c_q.cnt) < CMP_W'(c_q.cur));

    // R5: counting always begins at the first tick of a period
    assert_load_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.loaded) |-> (c_q.cnt == '0));
    // R9: a stopped block drives the output low on the next cycle
    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pwm_out);
endmodule

// File: rtl/pwm_fifo_top.sv
module pwm_fifo_top
    import pwm_fifo_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int PERIOD_W   = 16,
    parameter int SAMPLE_W   = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);
    logic [31:0]         ctrl_word;
    logic [PERIOD_W-1:0] period_val;
    logic                swrst;
    logic                run, tick, counting, fifo_pop, fifo_empty, fifo_ovf;
    logic [SAMPLE_W-1:0] fifo_head;
    logic [7:0]          occ;
    logic                sample_wr;

    pwm_ctrl_regs #(.ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ctrl_word(ctrl_word), .period_val(period_val),
        .swrst(swrst)
    );

    assign sample_wr = bus_wr && (bus_addr == ADDR_W'(OFF_SAMPLE));

    pwm_sample_fifo #(.DEPTH(FIFO_DEPTH), .SAMPLE_W(SAMPLE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(swrst), .push(sample_wr),
        .push_data(bus_wdata[SAMPLE_W-1:0]), .pop(fifo_pop), .head(fifo_head),
        .empty(fifo_empty), .occupancy(occ), .overflow(fifo_ovf)
    );

    assign run = ctrl_word[CB_EN] && (ctrl_word[CB_SEL_LO +: SEL_W] != '0);

    pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(counting), .div(ctrl_word[CB_DIV_LO +: DIV_W]),
        .tick(tick)
    );

    pwm_period_core #(.PERIOD_W(PERIOD_W), .SAMPLE_W(SAMPLE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .clear(swrst), .run(run), .tick(tick),
        .period_val(period_val), .fifo_head(fifo_head), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .counting(counting), .pwm_out(pwm_out)
    );

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFF_CTRL):   bus_rdata = ctrl_word;
            ADDR_W'(OFF_STATUS): bus_rdata = pack_status(occ, fifo_ovf);
            ADDR_W'(OFF_PERIOD): bus_rdata = 32'(period_val);
            default:             bus_rdata = '0;
        endcase
    end

    // R11: the queue is empty on the edge after the reset bit reads 1
    assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> (occ == 8'd0 && !fifo_ovf));
endmodule

// File: tb/sim_pwm_fifo_top.sv
module sim_pwm_fifo_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwm_fifo_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // {sel[1:0], div[11:0], period[15:0], sample[15:0]}
    localparam logic [45:0] VECS [0:6] = '{
        {2'd1, 12'd0,  16'd3,  16'd2},
        {2'd2, 12'd1,  16'd8,  16'd5},
        {2'd3, 12'd2,  16'd5,  16'd1},
        {2'd1, 12'd4,  16'd10, 16'd11},
        {2'd2, 12'd7,  16'd20, 16'd3},
        {2'd1, 12'd0,  16'd0,  16'd1},
        {2'd3, 12'd99, 16'd2,  16'd2}
    };

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic sw_reset();
        wr(5'h00, 32'h8);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic high_run(output int hi);
        int n = 0;
        while (pwm_out !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
        hi = 0;
        while (pwm_out === 1'b1 && hi < 5000) begin hi++; @(negedge clk); end
    endtask

    task automatic low_run(output int lo);
        lo = 0;
        while (pwm_out === 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
    endtask

    task automatic high_count(input int win, output int hi);
        hi = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (pwm_out === 1'b1) hi++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int hi, lo, exp_hi, exp_tot;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(5'h00, d); check("R1 ctrl", d, 0);
        rd(5'h04, d); check("R1 status", d, 0);
        rd(5'h10, d); check("R1 period", d, 0);
        rd(5'h08, d); check("R1 unmapped", d, 0);
        check("R1 pwm_out", pwm_out, 0);

        // R2: stored fields, period width, unmapped and sample reads
        wr(5'h00, 32'hFFFF_FFF6);
        rd(5'h00, d); check("R2 ctrl keep mask", d, 32'h01C3_FFF0);
        wr(5'h10, 32'h1234_ABCD);
        rd(5'h10, d); check("R2 period low half", d, 32'h0000_ABCD);
        rd(5'h0C, d); check("R2 sample reads zero", d, 0);

        // R11: software reset
        wr(5'h00, 32'h8);
        rd(5'h00, d); check("R11 bit3 set one cycle", d, 32'h8);
        rd(5'h10, d); check("R11 period cleared", d, 0);
        @(negedge clk);
        rd(5'h00, d); check("R11 bit3 cleared", d, 0);

        // R3/R4: fill queue beyond depth
        wr(5'h10, 32'd6);
        for (int i = 0; i < 4; i++) begin
            wr(5'h0C, 32'(2 * i + 1));
            rd(5'h04, d); check("R3 occupancy", d, i + 1);
        end
        wr(5'h0C, 32'd2);
        rd(5'h04, d); check("R4 full drop and flag", d, 32'h14);

        // R5: drain order, one per period, reuse when empty
        wr(5'h00, 32'h0001_0001);
        for (int i = 0; i < 5; i++) begin
            high_run(hi);
            check("R5 sample order", hi, (i < 4) ? 2 * i + 1 : 7);
        end
        rd(5'h04, d); check("R4 flag sticky, queue drained", d, 32'h10);

        // R11: reset flushes flag
        sw_reset();
        rd(5'h04, d); check("R11 status cleared", d, 0);

        // R8: sample 0 always low, large sample always high
        wr(5'h10, 32'd4);
        wr(5'h0C, 32'd0);
        wr(5'h00, 32'h0001_0001);
        high_count(30, hi); check("R8 zero sample low", hi, 0);
        wr(5'h0C, 32'd50);
        repeat (10) @(negedge clk);
        high_count(30, hi); check("R8 large sample high", hi, 30);

        // R9: enable clear stops output
        wr(5'h00, 32'h0001_0000);
        repeat (2) @(negedge clk);
        high_count(20, hi); check("R9 disabled low", hi, 0);

        // R10: select 0 stops counter, non-zero runs
        wr(5'h00, 32'h0000_0001);
        repeat (2) @(negedge clk);
        high_count(20, hi); check("R10 select zero idle", hi, 0);
        wr(5'h00, 32'h0002_0001);
        repeat (2) @(negedge clk);
        high_count(20, hi); check("R10 select two runs", hi, 20);

        // R6/R7/R8: vector table
        foreach (VECS[k]) begin
            sw_reset();
            wr(5'h10, 32'(VECS[k][31:16]));
            wr(5'h0C, 32'(VECS[k][15:0]));
            wr(5'h00, (32'(VECS[k][45:44]) << 16) | (32'(VECS[k][43:32]) << 4) | 32'h1);
            exp_hi  = int'(VECS[k][15:0]) * (int'(VECS[k][43:32]) + 1);
            exp_tot = (int'(VECS[k][31:16]) + 2) * (int'(VECS[k][43:32]) + 1);
            high_run(hi);
            low_run(lo);
            check("R8 R7 high time", hi, exp_hi);
            check("R6 R7 period", hi + lo, exp_tot);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule